// File: doc/BRIEF.md
# Set-Clear GPIO Port Controller

This block manages a port of general-purpose pins from a simple memory-mapped register bus. Each pin carries eight independent attributes:

- ownership (GPIO logic or a peripheral)
- choice between peripheral function A and function B
- output enable
- open-drain drive
- pull-up
- input glitch filter
- driven output data
- change-interrupt enable

Software never writes an attribute mask directly. It writes a one-hot or multi-bit mask to a set address or to a clear address, and only the bits written as one change. The current mask is read back from a status address. This makes every update atomic without a read-modify-write sequence.

Incoming pad levels pass through a two-flop synchronizer and an optional per-pin filter. The filter passes a level only after it has been seen for two consecutive samples. The resulting level is readable and is also handed to the peripherals. Any change of that level latches a bit in a change register. The change register clears when it is read. The interrupt line is the OR of the pending change bits that are also enabled.

On the output side, a per-pin multiplexer picks between the GPIO data/enable pair and one of two peripheral pairs. When open-drain mode is on, the multiplexer turns a driven one into a released pad.

Top module: `gpio_port`

## Requirements
- R1: After reset, the status words read: ownership all ones (GPIO), pull-up all ones, and every other attribute, the change register and `irq` all zero.
- R2: Byte address map. Bit 7 = 0 selects an attribute register, where bits 6:4 give the attribute index and bits 3:2 give the function, and bits 1:0 must be zero. Attribute indices: 0 ownership (1 = GPIO), 1 peripheral select (1 = B), 2 output enable, 3 open-drain, 4 pull-up, 5 filter, 6 output data, 7 interrupt enable. Functions: 0 set, 1 clear, 2 status. A write to a set address sets the mask bits given as one and leaves the others unchanged.
- R3: A write to a clear address clears the mask bits given as one and leaves the others unchanged.
- R4: Writes to a status address, to function 3, to address 0x80 or to address 0x84 change no attribute.
- R5: For a GPIO-owned pin that is not open-drain, `pad_out` equals its output data bit and `pad_oe` equals its output-enable bit, combinationally from the registers.
- R6: For a peripheral-owned pin, the pad output and enable come from the `pa_*` pair when the select bit is 0, and from the `pb_*` pair when it is 1.
- R7: With open-drain set, a drive value of 1 gives `pad_oe`=0, and a drive value of 0 gives `pad_oe` equal to the source's enable. `pad_out` is 0 in both cases.
- R8: `pad_pu` equals the pull-up mask.
- R9: A read at 0x80 returns the synchronized pin level whatever the pin's direction or owner. That level is also output on `periph_in`. The level reflects a pad change two clock edges after the change.
- R10: With the filter bit of a pin set, a pad pulse lasting one clock cycle changes neither the level nor the change register. With the filter bit clear, the same pulse is seen.
- R11: Every change of a pin's level sets its change bit. A read at 0x84 returns the change register and clears it in the same access. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R12: A change arriving in the same cycle as a read at 0x84 is left pending for the next read.
- R13: `irq` is high exactly when a pending change bit has its interrupt-enable bit set. Clearing all enable bits drops `irq` on the next cycle even though the changes stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NPINS | Registered read data |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad drive enables |
| pad_pu | output | NPINS | Pad pull-up enables |
| pa_out | input | NPINS | Peripheral A output values |
| pa_oe | input | NPINS | Peripheral A drive enables |
| pb_out | input | NPINS | Peripheral B output values |
| pb_oe | input | NPINS | Peripheral B drive enables |
| periph_in | output | NPINS | Synchronized pin levels to peripherals |
| irq | output | 1 | Change interrupt |

## Verification
The bench uses the default NPINS of 32. With that width, all-ones masks exercise the whole word, including the top pin 31. Pin 31 is also used as the enabled interrupt source. A few low pins are split between the two peripheral functions while the rest stay GPIO, so both halves of the multiplexer are checked in one pad word. Single-cycle pulses and a change placed exactly on the read-clear cycle give the filter and the pending-bit rule their edge cases.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int NATTR = 8;

    typedef enum logic [2:0] {
        A_OWN  = 3'd0,
        A_SELB = 3'd1,
        A_OE   = 3'd2,
        A_OD   = 3'd3,
        A_PU   = 3'd4,
        A_FILT = 3'd5,
        A_DATA = 3'd6,
        A_IEN  = 3'd7
    } attr_e;

    typedef enum logic [1:0] {
        F_SET  = 2'd0,
        F_CLR  = 2'd1,
        F_STAT = 2'd2,
        F_NONE = 2'd3
    } func_e;

    localparam logic [7:0] ADDR_LEVEL = 8'h80;
    localparam logic [7:0] ADDR_CHG   = 8'h84;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = (mask_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= RST;
        else        mask_q <= mask_d;
    end

    assign q_o = mask_q;
endmodule

// File: rtl/gpio_in_path.sv
module gpio_in_path #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    input  logic [W-1:0] filt_en_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] chg_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [W-1:0] filt;
        logic [W-1:0] prev;
    } in_t;

    in_t in_d, in_q;
    logic [W-1:0] stable;
    logic [W-1:0] level;

    always_comb begin
        stable     = ~(in_q.s2 ^ in_q.s3);
        level      = (filt_en_i & in_q.filt) | (~filt_en_i & in_q.s2);
        in_d.s1    = pad_i;
        in_d.s2    = in_q.s1;
        in_d.s3    = in_q.s2;
        in_d.filt  = (in_q.filt & ~stable) | (in_q.s2 & stable);
        in_d.prev  = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    assign level_o = level;
    assign chg_o   = level ^ in_q.prev;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own_i,
    input  logic [W-1:0] selb_i,
    input  logic [W-1:0] oe_i,
    input  logic [W-1:0] od_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] pa_out_i,
    input  logic [W-1:0] pa_oe_i,
    input  logic [W-1:0] pb_out_i,
    input  logic [W-1:0] pb_oe_i,
    output logic [W-1:0] pad_out_o,
    output logic [W-1:0] pad_oe_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic val, en;
        always_comb begin
            if (own_i[p]) begin
                val = data_i[p];
                en  = oe_i[p];
            end else if (selb_i[p]) begin
                val = pb_out_i[p];
                en  = pb_oe_i[p];
            end else begin
                val = pa_out_i[p];
                en  = pa_oe_i[p];
            end
            if (od_i[p]) begin
                pad_out_o[p] = 1'b0;
                pad_oe_o[p]  = en & ~val;
            end else begin
                pad_out_o[p] = val;
                pad_oe_o[p]  = en;
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic             bus_rd,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pu,
    input  logic [NPINS-1:0] pa_out,
    input  logic [NPINS-1:0] pa_oe,
    input  logic [NPINS-1:0] pb_out,
    input  logic [NPINS-1:0] pb_oe,
    output logic [NPINS-1:0] periph_in,
    output logic             irq
);
    typedef struct packed {
        logic [NPINS-1:0] rdata;
        logic [NPINS-1:0] isr;
    } regs_t;

    regs_t s_d, s_q;
    logic [NATTR-1:0][NPINS-1:0] attr_q;
    logic [NPINS-1:0] level, chg, rd_val;
    logic       is_attr, rd_chg;
    logic [2:0] attr_idx;
    logic [1:0] func;

    assign is_attr  = !bus_addr[7] && (bus_addr[1:0] == 2'b00);
    assign attr_idx = bus_addr[6:4];
    assign func     = bus_addr[3:2];

    for (genvar k = 0; k < NATTR; k++) begin : g_attr
        localparam logic [NPINS-1:0] RV =
            (k == int'(A_OWN) || k == int'(A_PU)) ? '1 : '0;
        logic hit;
        logic [NPINS-1:0] set_v, clr_v;
        assign hit   = bus_wr && is_attr && (attr_idx == 3'(k));
        assign set_v = (hit && func == F_SET) ? bus_wdata : '0;
        assign clr_v = (hit && func == F_CLR) ? bus_wdata : '0;
        gpio_setclr_reg #(.W(NPINS), .RST(RV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v),
            .clr_i (clr_v),
            .q_o   (attr_q[k])
        );
    end

    gpio_in_path #(.W(NPINS)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pad_in),
        .filt_en_i (attr_q[A_FILT]),
        .level_o   (level),
        .chg_o     (chg)
    );

    gpio_pad_mux #(.W(NPINS)) u_mux (
        .own_i     (attr_q[A_OWN]),
        .selb_i    (attr_q[A_SELB]),
        .oe_i      (attr_q[A_OE]),
        .od_i      (attr_q[A_OD]),
        .data_i    (attr_q[A_DATA]),
        .pa_out_i  (pa_out),
        .pa_oe_i   (pa_oe),
        .pb_out_i  (pb_out),
        .pb_oe_i   (pb_oe),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    always_comb begin
        if (is_attr && func == F_STAT) rd_val = attr_q[attr_idx];
        else if (bus_addr == ADDR_LEVEL) rd_val = level;
        else if (bus_addr == ADDR_CHG)   rd_val = s_q.isr;
        else                             rd_val = '0;
        rd_chg    = bus_rd && (bus_addr == ADDR_CHG);
        s_d.rdata = bus_rd ? rd_val : s_q.rdata;
        s_d.isr   = (rd_chg ? '0 : s_q.isr) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign pad_pu    = attr_q[A_PU];
    assign periph_in = level;
    assign irq       = |(s_q.isr & attr_q[A_IEN]);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_wr,
    input logic [NPINS-1:0] bus_wdata,
    input logic             bus_rd,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq,
    input logic [NPINS-1:0] own_q,
    input logic [NPINS-1:0] oe_q,
    input logic [NPINS-1:0] od_q,
    input logic [NPINS-1:0] data_q,
    input logic [NPINS-1:0] isr_q
);
    // R2
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h20) |=> ((oe_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h24) |=> ((oe_q & $past(bus_wdata)) == '0));

    // R7
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_q & od_q & data_q & pad_oe) == '0));

    // R11
    chg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h84) |=> (bus_rdata == $past(isr_q)));

    // R13
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h74 && bus_wdata == '1) |=> !irq);
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .own_q     (attr_q[0]),
    .oe_q      (attr_q[2]),
    .od_q      (attr_q[3]),
    .data_q    (attr_q[6]),
    .isr_q     (s_q.isr)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [NP-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, periph_in;
    logic [NP-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic [NP-1:0] exp_q[$];
    string tag_q[$];

    gpio_port #(.NPINS(NP)) u0 (.*);

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [NP-1:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expectation per completed read
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                logic [NP-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(8'h08, 32'hFFFF_FFFF, "R1 own");
        bus_read(8'h18, 32'h0, "R1 selb");
        bus_read(8'h28, 32'h0, "R1 oe");
        bus_read(8'h38, 32'h0, "R1 od");
        bus_read(8'h48, 32'hFFFF_FFFF, "R1 pu");
        bus_read(8'h58, 32'h0, "R1 filt");
        bus_read(8'h68, 32'h0, "R1 data");
        bus_read(8'h78, 32'h0, "R1 ien");
        bus_read(8'h84, 32'h0, "R1 chg");
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        // R2 set
        bus_write(8'h20, 32'h0000_00F0);
        bus_read(8'h28, 32'h0000_00F0, "R2 oe set");
        bus_write(8'h20, 32'h0000_0F00);
        bus_read(8'h28, 32'h0000_0FF0, "R2 oe set keeps");
        // R3 clear
        bus_write(8'h24, 32'h0000_0030);
        bus_read(8'h28, 32'h0000_0FC0, "R3 oe clr");
        // R4 ignored writes
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        bus_write(8'h80, 32'hFFFF_FFFF);
        bus_write(8'h84, 32'hFFFF_FFFF);
        bus_read(8'h28, 32'h0000_0FC0, "R4 oe unchanged");
        bus_read(8'h08, 32'hFFFF_FFFF, "R4 own unchanged");
        // R5 gpio drive
        bus_write(8'h60, 32'h0000_0140);
        idle(1);
        check("R5 pad_out", pad_out, 32'h0000_0140);
        check("R5 pad_oe", pad_oe, 32'h0000_0FC0);
        bus_write(8'h64, 32'h0000_0040);
        bus_read(8'h68, 32'h0000_0100, "R5 data clr");
        // R6 peripheral mux
        pa_out = 32'hAAAA_AAAA; pa_oe = 32'hFFFF_0000;
        pb_out = 32'h5555_5555; pb_oe = 32'h0000_FFFF;
        bus_write(8'h04, 32'h0000_000F);
        bus_write(8'h10, 32'h0000_0003);
        idle(1);
        check("R6 pad_out", pad_out, 32'h0000_0109);
        check("R6 pad_oe", pad_oe, 32'h0000_0FC3);
        bus_read(8'h08, 32'hFFFF_FFF0, "R6 own");
        bus_read(8'h18, 32'h0000_0003, "R6 selb");
        bus_write(8'h00, 32'h0000_000F);
        // R7 open drain
        bus_write(8'h30, 32'h0000_0300);
        idle(1);
        check("R7 pad_out", pad_out, 32'h0);
        check("R7 pad_oe", pad_oe, 32'h0000_0EC0);
        // R8 pull-up
        bus_write(8'h44, 32'hFFFF_0000);
        idle(1);
        check("R8 pad_pu", pad_pu, 32'h0000_FFFF);
        // R9 level
        pad_in = 32'h8000_0001;
        idle(4);
        bus_read(8'h80, 32'h8000_0001, "R9 level");
        check("R9 periph_in", periph_in, 32'h8000_0001);
        // R11 read clears
        bus_read(8'h84, 32'h8000_0001, "R11 chg");
        bus_read(8'h84, 32'h0, "R11 chg cleared");
        // R13 irq
        bus_write(8'h70, 32'h8000_0000);
        pad_in[31] = 1'b0;
        idle(5);
        check("R13 irq set", {31'h0, irq}, 32'h1);
        bus_read(8'h84, 32'h8000_0000, "R11 chg bit31");
        check("R13 irq after read", {31'h0, irq}, 32'h0);
        pad_in[31] = 1'b1;
        idle(5);
        check("R13 irq again", {31'h0, irq}, 32'h1);
        bus_write(8'h74, 32'hFFFF_FFFF);
        check("R13 irq masked", {31'h0, irq}, 32'h0);
        bus_read(8'h84, 32'h8000_0000, "R13 still pending");
        // R10 filter
        @(negedge clk) pad_in[4] = 1'b1;
        @(negedge clk) pad_in[4] = 1'b0;
        idle(6);
        bus_read(8'h84, 32'h0000_0010, "R10 unfiltered pulse");
        bus_write(8'h50, 32'h0000_0010);
        idle(3);
        @(negedge clk) pad_in[4] = 1'b1;
        @(negedge clk) pad_in[4] = 1'b0;
        idle(6);
        bus_read(8'h84, 32'h0, "R10 filtered pulse");
        pad_in[4] = 1'b1;
        idle(6);
        bus_read(8'h80, 32'h8000_0011, "R10 steady level");
        bus_read(8'h84, 32'h0000_0010, "R10 steady change");
        // R12 change on read cycle
        pad_in[3] = 1'b1;
        idle(6);
        @(negedge clk) pad_in[5] = 1'b1;
        @(negedge clk);
        bus_read(8'h84, 32'h0000_0008, "R12 first read");
        bus_read(8'h84, 32'h0000_0020, "R12 kept pending");
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule